// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Decoder with Pending Bank

Endpoints raise interrupts by writing a vector number to one doorbell word at the bottom of this block's register window. The block splits that number into a status-register select (the low `SEL_SHIFT` bits) and a bit index (the remaining upper bits). It then sets one pending bit in a bank of status words. Each status word owns one interrupt line towards the processor interrupt controller. Software services a line by reading its status word. The read returns the pending bits and clears them in the same cycle.

Inside a status word the bit index counts downwards from the top of the word's slice. Read data leaves the block byte-reversed, so software sees each word in big-endian byte order. Parameters select one of two layouts. The wide layout has 32 vectors per word, with words from offset 0x4. The compact layout has 8 vectors per word, each word owning its own byte lane, with words from offset 0x10. Doorbells that name a missing word or an index outside the slice change no pending state and set a sticky error flag.

Top module: `msi_doorbell_bank`

## Requirements
- R1: A write with `wr_en` high and `wr_addr` 0 carries vector `v = (index << SEL_SHIFT) | select`. It sets one pending bit in status word `select`, visible from the cycle after the write edge.
- R2: Index `n` is held at internal bit `hi - n`. In the wide layout `hi` is 31 for every word, so index 0 is bit 31 and index 31 is bit 0.
- R3: Read data is byte-reversed. Bus bits [7:0] carry internal bits [31:24], [15:8] carry [23:16], [23:16] carry [15:8], and [31:24] carry [7:0].
- R4: Status word `i` is read at byte offset `STAT_BASE + 4*i`. Its data appears on `rd_data` in the cycle after the edge that samples `rd_en`.
- R5: A read clears exactly the bits it returns. A doorbell for the same word in the same cycle is still pending afterwards.
- R6: `irq_o[i]` is high while word `i` holds any pending bit, and falls once a read has cleared it.
- R7: A doorbell whose select is not below `NUM_REGS`, or whose index is not below `VEC_PER_REG`, changes no pending bit. It sets `err_o`, which stays high until reset.
- R8: In the compact layout (`VEC_PER_REG` 8, `STAT_BASE` 0x10), word `i` uses internal bits [31-8i : 24-8i], with index 0 at bit 31-8i.
- R9: Reset clears every pending bit, `irq_o`, `err_o` and `rd_data`.
- R10: A read of any offset that is not a status word, including the doorbell, returns zero. A write to any offset other than 0 is ignored.
- R11: The vector space spans `32 << SEL_SHIFT` numbers. With `SEL_SHIFT` 3, vector 255 is index 31 of word 7, and vector 256 is rejected as out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data (vector number at the doorbell) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Registered, byte-reversed read data |
| irq_o | output | NUM_REGS | One interrupt line per status word |
| err_o | output | 1 | Sticky flag for rejected doorbells |

## Verification
Several vector patterns are written to the doorbell. A single mid-range vector shows whether the select and index fields are split at the right bit. The lowest and highest vectors expose a non-reversed or off-by-one bit order and wrong byte swapping. Vectors that share one word show whether a read clears only its own bits. A doorbell that lands in the same cycle as a read of its word tells a read-modify-write apart from a plain clear. Out-of-range, unmapped and misaddressed accesses are each checked at the outputs, and a second instance in the compact layout checks the per-word byte lanes and the missing-select case.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;

  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // highest internal bit of the slice owned by status word reg_idx
  function automatic int slice_hi(int vec_per_reg, int reg_idx);
    return (vec_per_reg >= WORD_W) ? (WORD_W - 1) : (WORD_W - 1 - vec_per_reg * reg_idx);
  endfunction

  // reversed placement: index 0 lands on the top bit of the slice
  function automatic logic [4:0] bit_pos(int hi, logic [4:0] idx);
    logic [4:0] top;
    top = 5'(hi);
    return top - idx;
  endfunction

  // bits a status word may legally hold
  function automatic word_t slice_mask(int vec_per_reg, int reg_idx);
    word_t ones;
    int    lo;
    lo   = slice_hi(vec_per_reg, reg_idx) - vec_per_reg + 1;
    ones = (vec_per_reg >= WORD_W) ? '1 : ((word_t'(1) << vec_per_reg) - word_t'(1));
    return ones << lo;
  endfunction

  // bus presentation: byte order reversed
  function automatic word_t to_bus(word_t w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/msi_db_decode.sv
module msi_db_decode
  import msi_db_pkg::*;
#(
  parameter int SEL_SHIFT   = 3,
  parameter int NUM_REGS    = 8,
  parameter int VEC_PER_REG = 32,
  parameter int ADDR_W      = 8
) (
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  word_t                      wr_data,
  output logic [NUM_REGS-1:0][WORD_W-1:0] set_vec,
  output logic                       bad_o
);
  localparam int SEL_W = SEL_SHIFT;

  logic             db_hit;
  logic [SEL_W-1:0] sel;
  word_t            idx32;
  logic             sel_ok;
  logic             idx_ok;

  assign db_hit = wr_en && (wr_addr == '0);
  assign sel    = wr_data[SEL_W-1:0];
  assign idx32  = wr_data >> SEL_SHIFT;
  assign sel_ok = 32'(sel) < 32'(NUM_REGS);
  assign idx_ok = idx32 < 32'(VEC_PER_REG);
  assign bad_o  = db_hit && !(sel_ok && idx_ok);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_set
    assign set_vec[i] = (db_hit && sel_ok && idx_ok && (sel == SEL_W'(i)))
                      ? (word_t'(1) << bit_pos(slice_hi(VEC_PER_REG, i), idx32[4:0]))
                      : '0;
  end

endmodule

// File: rtl/msi_db_status_bank.sv
module msi_db_status_bank
  import msi_db_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int VEC_PER_REG = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_REGS-1:0][WORD_W-1:0] set_vec,
  input  logic [NUM_REGS-1:0]             rd_clr,
  output logic [NUM_REGS-1:0][WORD_W-1:0] stat,
  output logic [NUM_REGS-1:0]             irq_o
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)         stat[i] <= '0;
      else if (rd_clr[i]) stat[i] <= set_vec[i];
      else                stat[i] <= stat[i] | set_vec[i];
    end

    assign irq_o[i] = |stat[i];

    AST_SET_BECOMES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec[i] != '0) |=> ((stat[i] & $past(set_vec[i])) == $past(set_vec[i]))); // R1
    AST_READ_CLEARS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr[i] && set_vec[i] == '0) |=> (stat[i] == '0)); // R5
    AST_IRQ_FALLS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o[i]) |-> $past(rd_clr[i])); // R6
    AST_PENDING_IN_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[i] & ~slice_mask(VEC_PER_REG, i)) == '0); // R8
  end

endmodule

// File: rtl/msi_db_readmux.sv
module msi_db_readmux
  import msi_db_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int ADDR_W    = 8,
  parameter int STAT_BASE = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic [NUM_REGS-1:0][WORD_W-1:0] stat,
  output logic [NUM_REGS-1:0]             rd_clr,
  output word_t                           rd_data
);
  word_t rd_next;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign rd_clr[i] = rd_en && (rd_addr == ADDR_W'(STAT_BASE + 4 * i));
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_clr[i]) rd_next = rd_next | to_bus(stat[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

  AST_ONE_WORD_PER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_clr)); // R4
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_clr == '0) |=> (rd_data == '0)); // R10

endmodule

// File: rtl/msi_doorbell_bank.sv
module msi_doorbell_bank
  import msi_db_pkg::*;
#(
  parameter int SEL_SHIFT   = 3,
  parameter int NUM_REGS    = 8,
  parameter int VEC_PER_REG = 32,
  parameter int STAT_BASE   = 4,
  parameter int ADDR_W      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [31:0]         rd_data,
  output logic [NUM_REGS-1:0] irq_o,
  output logic                err_o
);
  logic [NUM_REGS-1:0][WORD_W-1:0] set_vec;
  logic [NUM_REGS-1:0][WORD_W-1:0] stat;
  logic [NUM_REGS-1:0]             rd_clr;
  logic                            bad_db;
  logic                            err_q;

  msi_db_decode #(
    .SEL_SHIFT(SEL_SHIFT), .NUM_REGS(NUM_REGS),
    .VEC_PER_REG(VEC_PER_REG), .ADDR_W(ADDR_W)
  ) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .set_vec(set_vec), .bad_o(bad_db)
  );

  msi_db_status_bank #(
    .NUM_REGS(NUM_REGS), .VEC_PER_REG(VEC_PER_REG)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd_clr(rd_clr),
    .stat(stat), .irq_o(irq_o)
  );

  msi_db_readmux #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .STAT_BASE(STAT_BASE)
  ) u_rmux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .stat(stat), .rd_clr(rd_clr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (bad_db) err_q <= 1'b1;
  end
  assign err_o = err_q;

  AST_SINGLE_PENDING_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(set_vec) <= 1); // R1
  AST_REJECT_SETS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    bad_db |-> (set_vec == '0)); // R7
  AST_ERR_STAYS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R7
  AST_REJECT_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bad_db |=> err_o); // R7

endmodule

// File: tb/msi_doorbell_bank_tb.sv
module msi_doorbell_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk; // 200 MHz

  // wide layout instance
  logic       d_we = 0, d_re = 0;
  logic [7:0] d_wa = 0, d_ra = 0;
  logic [31:0] d_wd = 0, d_rd;
  logic [7:0] d_irq;
  logic       d_err;
  // compact layout instance
  logic       l_we = 0, l_re = 0;
  logic [7:0] l_wa = 0, l_ra = 0;
  logic [31:0] l_wd = 0, l_rd;
  logic [2:0] l_irq;
  logic       l_err;

  msi_doorbell_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(d_we), .wr_addr(d_wa), .wr_data(d_wd),
    .rd_en(d_re), .rd_addr(d_ra), .rd_data(d_rd), .irq_o(d_irq), .err_o(d_err));

  msi_doorbell_bank #(.SEL_SHIFT(2), .NUM_REGS(3), .VEC_PER_REG(8), .STAT_BASE(16)) dut_legacy_i (
    .clk(clk), .rst_n(rst_n), .wr_en(l_we), .wr_addr(l_wa), .wr_data(l_wd),
    .rd_en(l_re), .rd_addr(l_ra), .rd_data(l_rd), .irq_o(l_irq), .err_o(l_err));

  int n_chk = 0, n_fail = 0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // bench model: pending word as software sees it
  function automatic logic [31:0] exp_word(input bit leg, input int sel, input int idx);
    logic [31:0] inner, bus;
    int top;
    top = leg ? (31 - 8 * sel) : 31;
    inner = 32'h0;
    inner[top - idx] = 1'b1;
    for (int b = 0; b < 4; b++) bus[8*b +: 8] = inner[8*(3-b) +: 8];
    return bus;
  endfunction

  task automatic wr(input bit leg, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    if (leg) begin l_we = 1; l_wa = a; l_wd = d; end
    else     begin d_we = 1; d_wa = a; d_wd = d; end
    @(negedge clk);
    l_we = 0; d_we = 0;
  endtask

  task automatic rd(input bit leg, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    if (leg) begin l_re = 1; l_ra = a; end
    else     begin d_re = 1; d_ra = a; end
    @(negedge clk);
    d = leg ? l_rd : d_rd;
    l_re = 0; d_re = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R9 rd_data after reset", d_rd, 0);
    check("R9 irq after reset", {24'h0, d_irq}, 0);
    check("R9 err after reset", {31'h0, d_err}, 0);
    check("R9 legacy irq/err after reset", {28'h0, l_irq, l_err}, 0);
    for (int i = 0; i < 8; i++) begin
      rd(0, 8'(4 + 4 * i), v);
      check("R9 status word empty", v, 0);
    end
  endtask

  task automatic t_single();
    logic [31:0] v;
    wr(0, 0, (5 << 3) | 2);
    check("R6 irq for word 2", {24'h0, d_irq}, 32'h04);
    rd(0, 8'd12, v);
    check("R1 R2 R3 R4 vector 42", v, exp_word(0, 2, 5));
    check("R6 irq falls after read", {24'h0, d_irq}, 0);
    rd(0, 8'd12, v);
    check("R5 word cleared", v, 0);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    wr(0, 0, 0);
    wr(0, 0, 8);
    wr(0, 0, 255);
    check("R6 irq for words 0 and 7", {24'h0, d_irq}, 32'h81);
    rd(0, 8'd4, v);
    check("R2 R3 index 0 and 1 of word 0", v, exp_word(0, 0, 0) | exp_word(0, 0, 1));
    check("R5 read of word 0 spares word 7", {24'h0, d_irq}, 32'h80);
    rd(0, 8'd32, v);
    check("R11 vector 255 at word 7 index 31", v, exp_word(0, 7, 31));
  endtask

  task automatic t_coincident();
    logic [31:0] v;
    wr(0, 0, 3);
    @(negedge clk);
    d_we = 1; d_wa = 0; d_wd = (1 << 3) | 3;
    d_re = 1; d_ra = 8'd16;
    @(negedge clk);
    v = d_rd;
    d_we = 0; d_re = 0;
    check("R5 read returns old bits only", v, exp_word(0, 3, 0));
    check("R5 coincident doorbell keeps irq", {24'h0, d_irq}, 32'h08);
    rd(0, 8'd16, v);
    check("R5 coincident doorbell kept", v, exp_word(0, 3, 1));
  endtask

  task automatic t_reject();
    logic [31:0] v;
    wr(0, 0, 256);
    check("R7 R11 vector 256 raises error", {31'h0, d_err}, 1);
    check("R7 vector 256 sets nothing", {24'h0, d_irq}, 0);
    wr(0, 0, 1);
    check("R7 error stays after good doorbell", {31'h0, d_err}, 1);
    rd(0, 8'd8, v);
    check("R1 good doorbell after error", v, exp_word(0, 1, 0));
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(0, 0, 6);
    rd(0, 8'd0, v);
    check("R10 doorbell reads zero", v, 0);
    rd(0, 8'd36, v);
    check("R10 offset past bank reads zero", v, 0);
    check("R10 unmapped read keeps pending", {24'h0, d_irq}, 32'h40);
    rd(0, 8'd28, v);
    wr(0, 8'd8, 0);
    check("R10 write off doorbell ignored", {24'h0, d_irq}, 0);
  endtask

  task automatic t_legacy();
    logic [31:0] v;
    wr(1, 0, (2 << 2) | 1);
    check("R8 legacy irq word 1", {29'h0, l_irq}, 32'h2);
    rd(1, 8'd20, v);
    check("R8 legacy word 1 lane", v, exp_word(1, 1, 2));
    wr(1, 0, 0);
    wr(1, 0, (7 << 2) | 2);
    rd(1, 8'd16, v);
    check("R8 legacy word 0 index 0", v, exp_word(1, 0, 0));
    rd(1, 8'd24, v);
    check("R8 legacy word 2 index 7", v, exp_word(1, 2, 7));
    check("R7 legacy no error yet", {31'h0, l_err}, 0);
    wr(1, 0, 3);
    check("R7 missing select raises error", {31'h0, l_err}, 1);
    check("R7 missing select sets nothing", {29'h0, l_irq}, 0);
    rd(1, 8'd12, v);
    check("R10 legacy below base reads zero", v, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_edges();
    t_coincident();
    t_reject();
    t_unmapped();
    t_legacy();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule